// File: doc/BRIEF.md
# Control-Word Driven Register Datapath

This block is a clocked datapath around a bank of eight general registers. Each cycle one fixed-width control word steers it completely: two source register addresses feed two combinational read buses, a selector chooses whether the second bus carries a register or an external constant, a five-bit operation code drives an embedded function unit, a second selector picks either the function result or external data as the write-back value, and a write flag decides whether that value lands in the destination register at the next rising clock edge.

The first read bus is also presented as an address output and the second read bus as a data output, so the same word that computes also reads and writes memory-side operands. The function unit covers add, subtract, increment, decrement, transfer, bitwise AND/OR/XOR/NOT and single-position shifts, and reports carry, overflow, sign and zero for the current result. Sequencing and instruction decode are left to the logic that produces the control words.

Top module: `ctrl_datapath`

## Requirements
- R1: The 17-bit control word carries the destination address in bits 16:14, the first source address in bits 13:11, the second source address in bits 10:8, the bus-B selector in bit 7, the operation code in bits 6:2, the write-back selector in bit 1 and the write flag in bit 0; each 3-bit address value k names register k (0 to 7).
- R2: addr_out shows, in the same cycle, the register named by the first source address.
- R3: With bit 7 clear, data_out shows the register named by the second source address; with bit 7 set, data_out shows const_in, and the function unit's B operand is that same bus value.
- R4: With bit 1 clear the write-back value is the function result; with bit 1 set it is data_in.
- R5: With bit 0 set, the write-back value is stored into the destination register at the rising clock edge; a read of that register in the same cycle still shows the old value.
- R6: With bit 0 clear no register changes, whatever the other fields hold.
- R7: Operation codes with bits 4:3 = 00 are arithmetic: result = A + Y + bit 0, where bits 2:1 pick Y as 00 zero, 01 B, 10 bitwise-inverted B, 11 all ones (so 00101 gives A minus B and 00110 gives A minus 1).
- R8: Operation codes with bits 4:3 = 01 are bitwise: bits 2:1 pick 00 A AND B, 01 A OR B, 10 A XOR B, 11 NOT A (so 01100 with both sources equal clears the destination).
- R9: Operation codes with bit 4 set take B: bits 3:2 = 00 pass B, 01 shift B right one place, 10 shift B left one place (zero filled), 11 pass B.
- R10: flag_c is the adder carry out and flag_v the signed overflow for arithmetic codes, both 0 for any other code; flag_n is the result's top bit and flag_z is set when the result is all zeros.
- R11: An active-low reset clears all eight registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ctrl_word | input | 17 | Control word for this cycle |
| const_in | input | DW | Constant that may replace the second source bus |
| data_in | input | DW | External data that may be written back |
| addr_out | output | DW | First source bus |
| data_out | output | DW | Second source bus |
| flag_v | output | 1 | Signed overflow of the arithmetic result |
| flag_c | output | 1 | Carry out of the arithmetic result |
| flag_n | output | 1 | Sign bit of the function result |
| flag_z | output | 1 | Function result is zero |

## Verification
The two functions that meet in one cycle are the combinational read of a register and the clocked write to that same register. The bench issues words whose destination equals the first source, both as an increment of that register and as a load from data_in, and observes addr_out before the clock edge (it must still show the old contents) and again after the edge through a read-only word (it must show the new contents). A word with the write flag clear but a live destination, external data and operation is also issued to confirm nothing is stored.

// File: rtl/dp_pkg.sv
package dp_pkg;

  // B-operand shaping for the adder (operation code bits 2:1)
  typedef enum logic [1:0] {
    YB_ZERO = 2'b00,
    YB_PASS = 2'b01,
    YB_INV  = 2'b10,
    YB_ONES = 2'b11
  } ysel_e;

  // Bitwise operation (operation code bits 2:1)
  typedef enum logic [1:0] {
    LG_AND = 2'b00,
    LG_OR  = 2'b01,
    LG_XOR = 2'b10,
    LG_NOT = 2'b11
  } logic_e;

  // Shifter operation (operation code bits 3:2)
  typedef enum logic [1:0] {
    SH_PASS  = 2'b00,
    SH_RIGHT = 2'b01,
    SH_LEFT  = 2'b10,
    SH_HOLD  = 2'b11
  } shift_e;

  localparam int FSW = 5;

endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int DW = 8,
  parameter int AW = 3,
  localparam int NREG = 1 << AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  output logic [NREG*DW-1:0]  q_flat
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic          hit;
    logic [DW-1:0] q_nxt;
    logic [DW-1:0] q_r;

    always_comb begin
      hit   = wr_en && (wr_addr == AW'(g));
      q_nxt = hit ? wr_data : q_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_r <= '0;
      end else if (hit) begin
        q_r <= q_nxt;
      end
    end

    assign q_flat[g*DW +: DW] = q_r;
  end

endmodule

// File: rtl/dp_arith.sv
module dp_arith
  import dp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [1:0]    ysel,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          ovf
);

  logic [DW-1:0] y;
  logic [DW:0]   total;

  always_comb begin
    case (ysel_e'(ysel))
      YB_ZERO: y = '0;
      YB_PASS: y = b;
      YB_INV:  y = ~b;
      default: y = '1;
    endcase
    total = {1'b0, a} + {1'b0, y} + {{DW{1'b0}}, cin};
    sum   = total[DW-1:0];
    cout  = total[DW];
    ovf   = (a[DW-1] == y[DW-1]) && (total[DW-1] != a[DW-1]);
  end

endmodule

// File: rtl/dp_func_unit.sv
module dp_func_unit
  import dp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic [FSW-1:0] fs,
  output logic [DW-1:0]  f,
  output logic           c,
  output logic           v,
  output logic           n,
  output logic           z
);

  logic [DW-1:0] ar_sum;
  logic          ar_c;
  logic          ar_v;
  logic [DW-1:0] lg_res;
  logic [DW-1:0] sh_res;
  logic          is_arith;

  dp_arith #(.DW(DW)) u_arith (
    .a    (a),
    .b    (b),
    .ysel (fs[2:1]),
    .cin  (fs[0]),
    .sum  (ar_sum),
    .cout (ar_c),
    .ovf  (ar_v)
  );

  always_comb begin
    case (logic_e'(fs[2:1]))
      LG_AND:  lg_res = a & b;
      LG_OR:   lg_res = a | b;
      LG_XOR:  lg_res = a ^ b;
      default: lg_res = ~a;
    endcase

    case (shift_e'(fs[3:2]))
      SH_RIGHT: sh_res = {1'b0, b[DW-1:1]};
      SH_LEFT:  sh_res = {b[DW-2:0], 1'b0};
      default:  sh_res = b;
    endcase

    is_arith = (fs[4:3] == 2'b00);
    if (fs[4])       f = sh_res;
    else if (fs[3])  f = lg_res;
    else             f = ar_sum;

    c = is_arith & ar_c;
    v = is_arith & ar_v;
    n = f[DW-1];
    z = ~|f;
  end

endmodule

// File: rtl/ctrl_datapath.sv
module ctrl_datapath
  import dp_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3,
  localparam int CW = 3*AW + FSW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ctrl_word,
  input  logic [DW-1:0] const_in,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] addr_out,
  output logic [DW-1:0] data_out,
  output logic          flag_v,
  output logic          flag_c,
  output logic          flag_n,
  output logic          flag_z
);

  localparam int NREG   = 1 << AW;
  localparam int RW_POS = 0;
  localparam int MD_POS = 1;
  localparam int FS_LSB = 2;
  localparam int MB_POS = FS_LSB + FSW;
  localparam int BA_LSB = MB_POS + 1;
  localparam int AA_LSB = BA_LSB + AW;
  localparam int DA_LSB = AA_LSB + AW;

  logic [AW-1:0]      da, aa, ba;
  logic               mb_sel, md_sel, wr_en;
  logic [FSW-1:0]     fs;
  logic [NREG*DW-1:0] rf_flat;
  logic [DW-1:0]      bus_a, rd_b, bus_b, bus_d, fu_out;

  always_comb begin
    da     = ctrl_word[DA_LSB +: AW];
    aa     = ctrl_word[AA_LSB +: AW];
    ba     = ctrl_word[BA_LSB +: AW];
    mb_sel = ctrl_word[MB_POS];
    fs     = ctrl_word[FS_LSB +: FSW];
    md_sel = ctrl_word[MD_POS];
    wr_en  = ctrl_word[RW_POS];
  end

  // Read ports: combinational selection out of the register bank
  always_comb begin
    bus_a = '0;
    rd_b  = '0;
    for (int i = 0; i < NREG; i++) begin
      if (aa == AW'(i)) bus_a = rf_flat[i*DW +: DW];
      if (ba == AW'(i)) rd_b  = rf_flat[i*DW +: DW];
    end
    bus_b = mb_sel ? const_in : rd_b;
    bus_d = md_sel ? data_in  : fu_out;
  end

  dp_regfile #(.DW(DW), .AW(AW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (da),
    .wr_data (bus_d),
    .q_flat  (rf_flat)
  );

  dp_func_unit #(.DW(DW)) u_fu (
    .a  (bus_a),
    .b  (bus_b),
    .fs (fs),
    .f  (fu_out),
    .c  (flag_c),
    .v  (flag_v),
    .n  (flag_n),
    .z  (flag_z)
  );

  assign addr_out = bus_a;
  assign data_out = bus_b;

endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
  parameter int DW = 8,
  parameter int AW = 3,
  localparam int NREG = 1 << AW,
  localparam int CW = 3*AW + 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CW-1:0]      ctrl_word,
  input logic [DW-1:0]      const_in,
  input logic [DW-1:0]      data_in,
  input logic [DW-1:0]      data_out,
  input logic               flag_z,
  input logic               flag_n,
  input logic [DW-1:0]      bus_d,
  input logic [NREG*DW-1:0] rf_flat
);

  logic               last_rw;
  logic [AW-1:0]      last_da;
  logic [DW-1:0]      last_d;
  logic [NREG*DW-1:0] last_rf;
  logic [DW-1:0]      stored;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_rw <= 1'b0;
      last_da <= '0;
      last_d  <= '0;
      last_rf <= '0;
    end else begin
      last_rw <= ctrl_word[0];
      last_da <= ctrl_word[CW-1 -: AW];
      last_d  <= bus_d;
      last_rf <= rf_flat;
    end
  end

  always_comb begin
    stored = '0;
    for (int i = 0; i < NREG; i++)
      if (last_da == AW'(i)) stored = rf_flat[i*DW +: DW];
  end

  // R5: a flagged write leaves the write-back value in the destination
  assert_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_rw |-> (stored == last_d));

  // R6: with the write flag clear the bank holds still
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !last_rw |-> (rf_flat == last_rf));

  // R3: constant selected onto the second bus
  assert_const_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[7] |-> (data_out == const_in));

  // R4: external data selected for write-back
  assert_dsel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[1] |-> (bus_d == data_in));

  // R10: a zero result cannot be negative
  assert_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z |-> !flag_n);

endmodule

bind ctrl_datapath dp_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_word (ctrl_word),
  .const_in  (const_in),
  .data_in   (data_in),
  .data_out  (data_out),
  .flag_z    (flag_z),
  .flag_n    (flag_n),
  .bus_d     (bus_d),
  .rf_flat   (rf_flat)
);

// File: tb/ctrl_datapath_tb.sv
module ctrl_datapath_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [16:0] ctrl;
  logic [7:0]  cst;
  logic [7:0]  din;
  logic [7:0]  addr_out, data_out;
  logic        flag_v, flag_c, flag_n, flag_z;

  int nchk = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ctrl_datapath u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_word (ctrl),
    .const_in  (cst),
    .data_in   (din),
    .addr_out  (addr_out),
    .data_out  (data_out),
    .flag_v    (flag_v),
    .flag_c    (flag_c),
    .flag_n    (flag_n),
    .flag_z    (flag_z)
  );

  function automatic logic [16:0] mk(input logic [2:0] da, input logic [2:0] aa,
                                     input logic [2:0] ba, input logic mb,
                                     input logic [4:0] fs, input logic md,
                                     input logic rw);
    return {da, aa, ba, mb, fs, md, rw};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // drive one word; results are combinational now, the write lands at the next edge
  task automatic run(input logic [16:0] w, input logic [7:0] k, input logic [7:0] d);
    @(negedge clk);
    ctrl = w; cst = k; din = d;
    #1;
  endtask

  task automatic read_reg(input logic [2:0] idx, output logic [7:0] val);
    run(mk(3'd0, idx, 3'd0, 1'b0, 5'b00000, 1'b0, 1'b0), 8'h00, 8'h00);
    val = addr_out;
  endtask

  task automatic check_reg(input string req, input logic [2:0] idx, input logic [7:0] exp);
    logic [7:0] v;
    read_reg(idx, v);
    check(req, v, exp);
  endtask

  function automatic logic [7:0] flags();
    return {4'b0, flag_v, flag_c, flag_n, flag_z};
  endfunction

  task automatic t_reset_clear();
    for (int i = 0; i < 8; i++) check_reg("R11 reset clears register", 3'(i), 8'h00);
  endtask

  task automatic t_preload();
    logic [7:0] vals [8] = '{8'h03, 8'h11, 8'h24, 8'h07, 8'h5A, 8'h80, 8'hC3, 8'h7F};
    for (int i = 0; i < 8; i++)
      run(mk(3'(i), 3'd0, 3'd0, 1'b0, 5'b00000, 1'b1, 1'b1), 8'h00, vals[i]);
    for (int i = 0; i < 8; i++) check_reg("R1 R4 R5 data_in load", 3'(i), vals[i]);
  endtask

  task automatic t_arith();
    // R1 <- R2 + ~R3 + 1 : 24 - 07 = 1D, carry 1
    run(17'b001_010_011_0_00101_0_1, 8'h00, 8'h00);
    check("R10 subtract flags vcnz", flags(), 8'b0100);
    check_reg("R7 subtract", 3'd1, 8'h1D);
    // R7 <- R7 + 1 : 7F -> 80 signed overflow
    run(mk(3'd7, 3'd7, 3'd0, 1'b0, 5'b00001, 1'b0, 1'b1), 8'h00, 8'h00);
    check("R10 increment flags vcnz", flags(), 8'b1010);
    check_reg("R7 increment", 3'd7, 8'h80);
    // R5 <- R5 - 1 : 80 -> 7F
    run(mk(3'd5, 3'd5, 3'd0, 1'b0, 5'b00110, 1'b0, 1'b1), 8'h00, 8'h00);
    check("R10 decrement flags vcnz", flags(), 8'b1100);
    check_reg("R7 decrement", 3'd5, 8'h7F);
    // R2 <- R2 + R3 : 24 + 07
    run(mk(3'd2, 3'd2, 3'd3, 1'b0, 5'b00010, 1'b0, 1'b1), 8'h00, 8'h00);
    check_reg("R7 add", 3'd2, 8'h2B);
  endtask

  task automatic t_logic();
    run(mk(3'd0, 3'd4, 3'd6, 1'b0, 5'b01000, 1'b0, 1'b1), 8'h00, 8'h00);
    check("R10 logic clears carry/overflow", {6'b0, flag_v, flag_c}, 8'h00);
    check_reg("R8 AND", 3'd0, 8'h42);
    run(mk(3'd1, 3'd4, 3'd6, 1'b0, 5'b01010, 1'b0, 1'b1), 8'h00, 8'h00);
    check_reg("R8 OR", 3'd1, 8'hDB);
    run(mk(3'd3, 3'd4, 3'd0, 1'b0, 5'b01110, 1'b0, 1'b1), 8'h00, 8'h00);
    check("R10 NOT sign flag vcnz", flags(), 8'b0010);
    check_reg("R8 NOT", 3'd3, 8'hA5);
    run(mk(3'd5, 3'd0, 3'd0, 1'b0, 5'b01100, 1'b0, 1'b1), 8'h00, 8'h00);
    check("R10 XOR self zero flag vcnz", flags(), 8'b0001);
    check_reg("R8 XOR self clears", 3'd5, 8'h00);
  endtask

  task automatic t_shift();
    run(17'b100_000_110_0_11000_0_1, 8'h00, 8'h00);
    check_reg("R9 shift left", 3'd4, 8'h86);
    run(mk(3'd2, 3'd0, 3'd6, 1'b0, 5'b10100, 1'b0, 1'b1), 8'h00, 8'h00);
    check_reg("R9 shift right", 3'd2, 8'h61);
    run(mk(3'd7, 3'd0, 3'd0, 1'b1, 5'b10000, 1'b0, 1'b1), 8'h3C, 8'h00);
    check("R3 constant on data_out", data_out, 8'h3C);
    check_reg("R9 pass constant", 3'd7, 8'h3C);
    run(mk(3'd1, 3'd0, 3'd6, 1'b0, 5'b11100, 1'b0, 1'b1), 8'h00, 8'h00);
    check_reg("R9 code 11 passes B", 3'd1, 8'hC3);
  endtask

  task automatic t_buses();
    run(mk(3'd0, 3'd4, 3'd6, 1'b0, 5'b00000, 1'b0, 1'b0), 8'h99, 8'h00);
    check("R2 addr_out shows first source", addr_out, 8'h86);
    check("R3 data_out shows second source", data_out, 8'hC3);
    run(mk(3'd0, 3'd4, 3'd6, 1'b1, 5'b00000, 1'b0, 1'b0), 8'h99, 8'h00);
    check("R3 data_out shows constant", data_out, 8'h99);
  endtask

  task automatic t_no_write();
    run(mk(3'd2, 3'd4, 3'd6, 1'b0, 5'b00000, 1'b1, 1'b0), 8'h00, 8'hEE);
    check_reg("R6 data_in not stored", 3'd2, 8'h61);
    run(mk(3'd0, 3'd4, 3'd6, 1'b0, 5'b00010, 1'b0, 1'b0), 8'h00, 8'h00);
    check_reg("R6 function not stored", 3'd0, 8'h42);
  endtask

  task automatic t_same_cycle();
    run(mk(3'd3, 3'd3, 3'd0, 1'b0, 5'b00001, 1'b0, 1'b1), 8'h00, 8'h00);
    check("R5 same-cycle read is old", addr_out, 8'hA5);
    check_reg("R5 increment in place", 3'd3, 8'hA6);
    run(mk(3'd3, 3'd3, 3'd0, 1'b0, 5'b00000, 1'b1, 1'b1), 8'h00, 8'h55);
    check("R5 same-cycle read before load", addr_out, 8'hA6);
    check_reg("R5 R4 load in place", 3'd3, 8'h55);
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset_clear();
  endtask

  initial begin
    rst_n = 1'b0;
    ctrl = '0; cst = '0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_clear();
    t_preload();
    t_arith();
    t_logic();
    t_shift();
    t_buses();
    t_no_write();
    t_same_cycle();
    t_mid_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, nchk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nchk++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, nchk);
      $finish;
    end
  end

endmodule